// File: doc/BRIEF.md
# Page-Tracked Stream Prefetcher

This block sits beside a cache and watches the addresses of its demand misses. It keeps a small, recency-ordered table of the 4 KiB pages that were touched most recently. For each page it remembers the line index of the last access. Two accesses to the same page with a strictly increasing line index confirm an ascending stream. The access that confirms it requests the next higher line. A strictly decreasing pair confirms a descending stream and requests the next lower line. A prefetch never leaves the 4 KiB page of the access that caused it.

The request leaves through a valid/ready port that holds a single pending slot, and a newer request overwrites an older one still waiting there. A page that drops out of the table loses its history. The least recently used page is replaced when a new page arrives. A disable bit in the configuration word stops every prefetch and empties the slot.

The output slot is a two-state machine. SLOT_EMPTY moves to SLOT_FULL when a request is produced (transition LOAD). SLOT_FULL stays in SLOT_FULL on a newer request (REPLACE) or while the consumer is not ready (HOLD). It returns to SLOT_EMPTY when the consumer accepts with no new request (DRAIN). Either state goes to SLOT_EMPTY whenever the disable bit is set (KILL).

Top module: `page_stream_prefetcher`

## Requirements
- R1: After reset `pf_valid` is low and every page entry is invalid, so the first access to any page produces no prefetch.
- R2: An access to a page not in the table takes the least recently used entry, records the line index (address bits [11:6]) and requests no prefetch.
- R3: An access that hits a page whose last line index is smaller than its own requests line index+1 of the same page: `pf_addr` = {address[31:12], index+1, 6'b0}.
- R4: An access that hits a page whose last line index is larger than its own requests line index-1 of the same page: `pf_addr` = {address[31:12], index-1, 6'b0}.
- R5: An access that hits a page with an equal last line index requests nothing.
- R6: An ascending access at line index 63 and a descending access at line index 0 request nothing, because the target would leave the page.
- R7: The table holds 16 pages. If a page is referenced again after at most 15 other distinct pages, its history is kept. After 16 other distinct pages, its history is gone and the next reference counts as a first access.
- R8: A hit moves the page to most recently used and keeps its recorded line index.
- R9: While bit 9 of `cfg_word` is 1, no prefetch is issued, and a pending request is dropped at the next clock edge.
- R10: While `pf_ready` is low, a pending request keeps `pf_valid` high and `pf_addr` stable, unless a newer request replaces it. A request accepted with no newer request clears `pf_valid` at the next edge.
- R11: A prefetch appears on `pf_valid`/`pf_addr` one clock edge after the demand access that caused it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 16 | Configuration word; bit 9 set disables prefetching |
| dm_valid | input | 1 | Demand miss address valid |
| dm_addr | input | 32 | Demand miss byte address |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Consumer accepts the prefetch request |
| pf_addr | output | 32 | Line-aligned prefetch byte address |

## Verification
The bench sweeps first and second line indices over many fresh pages. A wrong direction compare shows up as a prefetch on equal indices or a target off by one, and missing edge suppression shows up as a request at line 0 minus one or line 63 plus one. Recency is tested at exactly 15 and 16 intervening pages. An off-by-one LRU would keep a page it should drop, or lose a page it should keep, and a hit that failed to refresh recency would lose a page that was recently touched. The slot is tested with the consumer stalled, with a replacing request and with the disable bit set. A design that queues requests, lets the address drift or keeps a request after disable fails those checks.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_t;
endpackage

// File: rtl/pfx_page_table.sv
module pfx_page_table #(
    parameter int PN_W  = 20,
    parameter int LI_W  = 6,
    parameter int PAGES = 16,
    localparam int AGE_W = $clog2(PAGES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic [PN_W-1:0] acc_page,
    input  logic [LI_W-1:0] acc_line,
    output logic            hit,
    output logic [LI_W-1:0] prev_line
);
    logic            ent_vld  [PAGES];
    logic [PN_W-1:0] ent_tag  [PAGES];
    logic [LI_W-1:0] ent_last [PAGES];
    logic [AGE_W-1:0] ent_age [PAGES];
    logic [PAGES-1:0] hit_vec;
    logic [PAGES-1:0] old_vec;
    logic [AGE_W-1:0] hit_idx, victim, sel, sel_age;

    for (genvar g = 0; g < PAGES; g++) begin : g_cmp
        assign hit_vec[g] = ent_vld[g] && (ent_tag[g] == acc_page);
        assign old_vec[g] = (ent_age[g] == AGE_W'(PAGES - 1));
    end

    always_comb begin
        hit_idx = '0;
        victim  = '0;
        for (int i = 0; i < PAGES; i++) begin
            if (hit_vec[i]) hit_idx = AGE_W'(i);
            if (old_vec[i]) victim  = AGE_W'(i);
        end
        hit       = |hit_vec;
        sel       = hit ? hit_idx : victim;
        sel_age   = ent_age[sel];
        prev_line = ent_last[hit_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGES; i++) begin
                ent_vld[i]  <= 1'b0;
                ent_tag[i]  <= '0;
                ent_last[i] <= '0;
                ent_age[i]  <= AGE_W'(i);
            end
        end else if (acc_valid) begin
            for (int i = 0; i < PAGES; i++) begin
                if (AGE_W'(i) == sel) begin
                    ent_vld[i]  <= 1'b1;
                    ent_tag[i]  <= acc_page;
                    ent_last[i] <= acc_line;
                    ent_age[i]  <= '0;
                end else if (ent_age[i] < sel_age) begin
                    ent_age[i]  <= ent_age[i] + 1'b1;
                end
            end
        end
    end

    // R7
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
    // R7
    single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n) $countones(old_vec) == 1);
    // R8
    mru_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && $past(acc_valid) && $stable(acc_page)) |-> hit);
endmodule

// File: rtl/pfx_out_slot.sv
module pfx_out_slot
    import pfx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kill,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);
    slot_state_t state, state_nx;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            SLOT_EMPTY: if (req_valid) state_nx = SLOT_FULL;
            SLOT_FULL:  if (!req_valid && pf_ready) state_nx = SLOT_EMPTY;
            default:    state_nx = SLOT_EMPTY;
        endcase
        if (kill) state_nx = SLOT_EMPTY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SLOT_EMPTY;
            addr_q <= '0;
        end else begin
            state <= state_nx;
            if (req_valid && !kill) addr_q <= req_addr;
        end
    end

    always_comb begin
        pf_valid = (state == SLOT_FULL);
        pf_addr  = addr_q;
    end

    // R9
    kill_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) kill |=> !pf_valid);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && !kill && !req_valid) |=> (pf_valid && $stable(pf_addr)));
    // R10
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready && !req_valid) |=> !pf_valid);
endmodule

// File: rtl/page_stream_prefetcher.sv
module page_stream_prefetcher #(
    parameter int ADDR_W   = 32,
    parameter int PAGE_SH  = 12,
    parameter int LINE_SH  = 6,
    parameter int PAGES    = 16,
    parameter int CFG_W    = 16,
    parameter int DIS_BIT  = 9,
    localparam int LI_W    = PAGE_SH - LINE_SH,
    localparam int PN_W    = ADDR_W - PAGE_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic              dm_valid,
    input  logic [ADDR_W-1:0] dm_addr,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);
    logic [PN_W-1:0] page;
    logic [LI_W-1:0] idx, prev_line, tgt;
    logic            hit, up, down, req_valid, kill;
    logic [ADDR_W-1:0] req_addr;

    assign page = dm_addr[ADDR_W-1:PAGE_SH];
    assign idx  = dm_addr[PAGE_SH-1:LINE_SH];
    assign kill = cfg_word[DIS_BIT];

    pfx_page_table #(.PN_W(PN_W), .LI_W(LI_W), .PAGES(PAGES)) u_table (
        .clk(clk), .rst_n(rst_n), .acc_valid(dm_valid), .acc_page(page),
        .acc_line(idx), .hit(hit), .prev_line(prev_line)
    );

    always_comb begin
        up        = hit && (idx > prev_line);
        down      = hit && (idx < prev_line);
        tgt       = up ? idx + 1'b1 : idx - 1'b1;
        req_valid = dm_valid && !kill &&
                    ((up && idx != {LI_W{1'b1}}) || (down && idx != '0));
        req_addr  = {page, tgt, {LINE_SH{1'b0}}};
    end

    pfx_out_slot #(.ADDR_W(ADDR_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .kill(kill), .req_valid(req_valid),
        .req_addr(req_addr), .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    // R11
    cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(pf_valid) |-> $past(dm_valid));
    // R6
    same_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> (pf_addr[ADDR_W-1:PAGE_SH] == $past(dm_addr[ADDR_W-1:PAGE_SH])));
endmodule

// File: tb/page_stream_prefetcher_test.sv
module page_stream_prefetcher_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] cfg_word = 0;
    logic        dm_valid = 0;
    logic [31:0] dm_addr = 0;
    logic        pf_ready = 1;
    logic        pf_valid;
    logic [31:0] pf_addr;
    int errors = 0;
    int checks = 0;

    page_stream_prefetcher uut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .dm_valid(dm_valid),
        .dm_addr(dm_addr), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] mk(input int pg, input int ln);
        return {pg[19:0], ln[5:0], 6'b0};
    endfunction

    task automatic chk(input logic ev, input logic [31:0] ea, input string req);
        checks++;
        if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
            errors++;
            $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h", req, pf_valid, pf_addr, ev, ea);
        end
    endtask

    // one access; returns at the negedge after the sampling edge
    task automatic acc(input int pg, input int ln);
        @(negedge clk);
        dm_valid = 1;
        dm_addr  = mk(pg, ln);
        @(negedge clk);
        dm_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #4000000;
        errors++;
        checks++;
        $display("FAIL watchdog: valid=%0b addr=%h expected valid=0 addr=0", pf_valid, pf_addr);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int fresh;
        logic [31:0] a1;
        fresh = 1000;
        idle(3);
        rst_n = 1;
        idle(1);
        chk(0, 0, "R1 reset");
        acc(7, 5);
        chk(0, 0, "R1 first access after reset");

        // R2..R6 sweep on fresh pages
        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 64; b += 7) begin
                fresh++;
                acc(fresh, a);
                chk(0, 0, "R2 new page");
                acc(fresh, b);
                if (b > a && b != 63)      chk(1, mk(fresh, b + 1), "R3 ascending");
                else if (b < a && b != 0)  chk(1, mk(fresh, b - 1), "R4 descending");
                else if (b == a)           chk(0, 0, "R5 equal");
                else                       chk(0, 0, "R6 edge");
            end
        end
        // explicit edges
        fresh++; acc(fresh, 62); acc(fresh, 63); chk(0, 0, "R6 top edge");
        fresh++; acc(fresh, 1);  acc(fresh, 0);  chk(0, 0, "R6 bottom edge");

        // R7 keep after 15 others
        acc(5000, 10);
        for (int k = 1; k <= 15; k++) acc(5000 + k, 3);
        acc(5000, 11);
        chk(1, mk(5000, 12), "R7 kept after 15");
        // R7 lose after 16 others
        acc(6000, 20);
        for (int k = 1; k <= 16; k++) acc(6000 + k, 3);
        acc(6000, 21);
        chk(0, 0, "R7 lost after 16");
        acc(6000, 22);
        chk(1, mk(6000, 23), "R7 relearned");

        // R8 hit refreshes recency and keeps index
        acc(7000, 30);
        for (int k = 1; k <= 10; k++) acc(7000 + k, 3);
        acc(7000, 30);
        chk(0, 0, "R8 equal index kept");
        for (int k = 11; k <= 25; k++) acc(7000 + k, 3);
        acc(7000, 29);
        chk(1, mk(7000, 28), "R8 refreshed page kept");

        // R11 timing: nothing before the sampling edge
        acc(8000, 4);
        @(negedge clk);
        dm_valid = 1; dm_addr = mk(8000, 9);
        #5;
        chk(0, 0, "R11 not before edge");
        @(negedge clk);
        dm_valid = 0;
        chk(1, mk(8000, 10), "R11 after one edge");

        // R10 hold, replace, drain
        idle(1);
        pf_ready = 0;
        acc(9000, 40);
        acc(9000, 41);
        a1 = mk(9000, 42);
        idle(3);
        chk(1, a1, "R10 held while stalled");
        acc(9000, 45);
        chk(1, mk(9000, 46), "R10 replaced");
        idle(2);
        chk(1, mk(9000, 46), "R10 replacement held");
        pf_ready = 1;
        idle(1);
        chk(0, 0, "R10 drained after accept");

        // R9 disable
        cfg_word = 16'h0200;
        acc(9100, 1);
        acc(9100, 2);
        chk(0, 0, "R9 disabled no issue");
        cfg_word = 16'h0000;
        acc(9100, 3);
        chk(1, mk(9100, 4), "R9 enabled again");
        cfg_word = 16'hFDFF;
        acc(9100, 5);
        chk(1, mk(9100, 6), "R9 other bits ignored");
        cfg_word = 0;
        pf_ready = 0;
        acc(9100, 7);
        chk(1, mk(9100, 8), "R9 pending before disable");
        cfg_word = 16'h0200;
        idle(1);
        chk(0, 0, "R9 pending dropped");
        cfg_word = 0;
        pf_ready = 1;
        idle(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule